// File: doc/BRIEF.md
# Link Speed-Change Stall Recovery Monitor

This block watches two debug words from a serial link controller and decides, each time it is asked, whether a transition to the higher link speed has stalled in the receiver-lock recovery state. The stalled case is the one in which the training state machine reports recovery receiver lock and the PHY does not report valid received data. When it finds a stall, the block works the link loose through the PHY's register access port. It turns on two receiver override controls, keeps them on for a programmable number of cycles, then turns them off again. Both changes are read-modify-write, so the other bits of that PHY register keep their values.

A supervisor pulses `chk_en` at its polling rate and holds the current debug words on the same cycle. Every PHY access goes through a level request / one-cycle completion port, which the surrounding logic provides. A one-cycle `recover_evt` marks each recovery that starts. `err_flag` records that the port reported an error and the sequence was abandoned.

States and transitions, named as in the RTL:
- `ST_IDLE` moves to `ST_RX_RD` on a qualified check.
- `ST_RX_RD` moves to `ST_SET_RD` when receive-valid reads back as 0, and returns to `ST_IDLE` when it reads 1 or the access fails.
- `ST_SET_RD` moves to `ST_SET_WR`.
- `ST_SET_WR` moves to `ST_HOLD`.
- `ST_HOLD` moves to `ST_CLR_RD` when the timer expires.
- `ST_CLR_RD` moves to `ST_CLR_WR`.
- `ST_CLR_WR` returns to `ST_IDLE`.
- Any completion that reports an error moves from the current request state to `ST_IDLE`.

Top module: `lsr_stall_recover`

## Requirements
- R1: After reset `phy_req`, `recover_evt`, `err_flag` and `busy` are all 0.
- R2: A check pulse is ignored, and no PHY access follows, when bit 4 of `dbg_hi` (link still busy) is 1.
- R3: A check pulse is ignored, and no PHY access follows, when `dbg_lo[5:0]` is not 6'h0D (recovery receiver lock).
- R4: A qualified check first reads PHY address 16'h100D. If bit 0 of the data read (receive valid) is 1, the block returns to idle after that single access and raises no event.
- R5: If receive valid is 0, `recover_evt` pulses for exactly one cycle. In that same cycle the block requests a read of address 16'h1005. It then writes back the value read with bits 5 and 3 set.
- R6: After the set write completes, `phy_req` stays low for exactly HOLD_CYC cycles.
- R7: After the hold, the block reads 16'h1005 again and writes back the value read with bits 5 and 3 cleared, then returns to idle. A full recovery takes five accesses.
- R8: Check pulses that arrive while `busy` is 1 have no effect.
- R9: A completion with `phy_err` = 1 ends the sequence at once. The block returns to idle with no further access and sets `err_flag`. Overrides already written stay in place. The next check pulse taken in idle clears `err_flag`.
- R10: While `phy_req` is 1 and no completion has arrived, `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | One-cycle request to evaluate the debug words |
| dbg_lo | input | 32 | First debug word; training state in bits 5:0 |
| dbg_hi | input | 32 | Second debug word; bit 4 = link busy |
| phy_req | output | 1 | PHY access request, held until completion |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_done | input | 1 | One-cycle completion of the current access |
| phy_rdata | input | 16 | Read data, valid with `phy_done` |
| phy_err | input | 1 | Access error, valid with `phy_done` |
| recover_evt | output | 1 | One-cycle pulse when a recovery starts |
| err_flag | output | 1 | Sticky port-error indication |
| busy | output | 1 | A sequence is in progress |

## Verification
A check taken at a clock edge shows on `busy` and `phy_req` in the cycle that follows. Each completion moves the block to its next request, or back to idle, one edge later. `recover_evt` rises at the same edge as the set-read request. The bench drives inputs and samples outputs at falling edges. It waits on `busy` before it compares access counts, the event count and the PHY register image. The hold is measured by counting the falling edges on which `phy_req` is low, from the edge after the set-write completion is seen to the next request.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RX_RD  = 3'd1,
        ST_SET_RD = 3'd2,
        ST_SET_WR = 3'd3,
        ST_HOLD   = 3'd4,
        ST_CLR_RD = 3'd5,
        ST_CLR_WR = 3'd6
    } lsr_state_e;

    function automatic logic is_req_state(lsr_state_e s);
        return (s == ST_RX_RD) || (s == ST_SET_RD) || (s == ST_SET_WR) ||
               (s == ST_CLR_RD) || (s == ST_CLR_WR);
    endfunction

endpackage

// File: rtl/lsr_trigger.sv
module lsr_trigger #(
    parameter int DBG_W      = 32,
    parameter int BUSY_BIT   = 4,
    parameter int STATE_W    = 6,
    parameter int STUCK_CODE = 13
) (
    input  logic [DBG_W-1:0] dbg_lo,
    input  logic [DBG_W-1:0] dbg_hi,
    output logic             qualify
);
    localparam logic [STATE_W-1:0] STUCK = STATE_W'(STUCK_CODE);

    logic link_busy;
    logic state_match;
    logic unused_dbg_bits;

    assign link_busy       = dbg_hi[BUSY_BIT];
    assign state_match     = (dbg_lo[STATE_W-1:0] == STUCK);
    assign qualify         = !link_busy && state_match;
    assign unused_dbg_bits = ^{dbg_lo, dbg_hi};
endmodule

// File: rtl/lsr_hold_timer.sv
module lsr_hold_timer #(
    parameter int HOLD_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [HOLD_W-1:0] cnt_q;
    logic              active_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            cnt_q    <= HOLD_W'(HOLD_CYC - 1);
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign expired = active_q && (cnt_q == '0);
endmodule

// File: rtl/lsr_seq_fsm.sv
module lsr_seq_fsm
    import lsr_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int RXST_ADDR    = 'h100D,
    parameter int OVRD_ADDR    = 'h1005,
    parameter int RXV_BIT      = 0,
    parameter int DATA_EN_BIT  = 5,
    parameter int PLL_EN_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              qualify,
    input  logic              hold_expired,
    output logic              hold_start,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_done,
    input  logic [DATA_W-1:0] phy_rdata,
    input  logic              phy_err,
    output logic              recover_evt,
    output logic              err_flag,
    output logic              busy
);
    localparam logic [DATA_W-1:0] OVRD_MASK =
        (DATA_W'(1) << DATA_EN_BIT) | (DATA_W'(1) << PLL_EN_BIT);
    localparam logic [ADDR_W-1:0] A_RXST = ADDR_W'(RXST_ADDR);
    localparam logic [ADDR_W-1:0] A_OVRD = ADDR_W'(OVRD_ADDR);

    lsr_state_e        state_q, state_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;
    logic              evt_d;
    logic              ok_done;
    logic              bad_done;

    assign ok_done  = phy_done && !phy_err;
    assign bad_done = phy_done && phy_err;

    // next-state and data capture
    always_comb begin
        state_d = state_q;
        wdata_d = wdata_q;
        evt_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (chk_en && qualify) state_d = ST_RX_RD;
            end
            ST_RX_RD: begin
                if (bad_done) state_d = ST_IDLE;
                else if (ok_done) begin
                    if (phy_rdata[RXV_BIT]) state_d = ST_IDLE;
                    else begin
                        state_d = ST_SET_RD;
                        evt_d   = 1'b1;
                    end
                end
            end
            ST_SET_RD: begin
                if (bad_done) state_d = ST_IDLE;
                else if (ok_done) begin
                    state_d = ST_SET_WR;
                    wdata_d = phy_rdata | OVRD_MASK;
                end
            end
            ST_SET_WR: begin
                if (bad_done)     state_d = ST_IDLE;
                else if (ok_done) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_expired) state_d = ST_CLR_RD;
            end
            ST_CLR_RD: begin
                if (bad_done) state_d = ST_IDLE;
                else if (ok_done) begin
                    state_d = ST_CLR_WR;
                    wdata_d = phy_rdata & ~OVRD_MASK;
                end
            end
            ST_CLR_WR: begin
                if (phy_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wdata_q     <= '0;
            recover_evt <= 1'b0;
            err_flag    <= 1'b0;
        end else begin
            state_q     <= state_d;
            wdata_q     <= wdata_d;
            recover_evt <= evt_d;
            if ((state_q != ST_IDLE) && bad_done) err_flag <= 1'b1;
            else if ((state_q == ST_IDLE) && chk_en) err_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        phy_req    = is_req_state(state_q);
        phy_we     = 1'b0;
        phy_addr   = A_OVRD;
        phy_wdata  = '0;
        busy       = (state_q != ST_IDLE);
        hold_start = (state_q == ST_SET_WR) && ok_done;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RX_RD:  phy_addr = A_RXST;
            ST_SET_RD: ;
            ST_SET_WR: begin phy_we = 1'b1; phy_wdata = wdata_q; end
            ST_HOLD:   ;
            ST_CLR_RD: ;
            ST_CLR_WR: begin phy_we = 1'b1; phy_wdata = wdata_q; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/lsr_stall_recover.sv
module lsr_stall_recover #(
    parameter int DBG_W       = 32,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BUSY_BIT    = 4,
    parameter int STATE_W     = 6,
    parameter int STUCK_CODE  = 13,
    parameter int RXST_ADDR   = 'h100D,
    parameter int OVRD_ADDR   = 'h1005,
    parameter int RXV_BIT     = 0,
    parameter int DATA_EN_BIT = 5,
    parameter int PLL_EN_BIT  = 3,
    parameter int HOLD_CYC    = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [DBG_W-1:0]  dbg_lo,
    input  logic [DBG_W-1:0]  dbg_hi,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_done,
    input  logic [DATA_W-1:0] phy_rdata,
    input  logic              phy_err,
    output logic              recover_evt,
    output logic              err_flag,
    output logic              busy
);
    logic qualify;
    logic hold_start;
    logic hold_expired;

    lsr_trigger #(
        .DBG_W     (DBG_W),
        .BUSY_BIT  (BUSY_BIT),
        .STATE_W   (STATE_W),
        .STUCK_CODE(STUCK_CODE)
    ) u_trig (
        .dbg_lo (dbg_lo),
        .dbg_hi (dbg_hi),
        .qualify(qualify)
    );

    lsr_hold_timer #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_start),
        .expired(hold_expired)
    );

    lsr_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RXST_ADDR  (RXST_ADDR),
        .OVRD_ADDR  (OVRD_ADDR),
        .RXV_BIT    (RXV_BIT),
        .DATA_EN_BIT(DATA_EN_BIT),
        .PLL_EN_BIT (PLL_EN_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_en      (chk_en),
        .qualify     (qualify),
        .hold_expired(hold_expired),
        .hold_start  (hold_start),
        .phy_req     (phy_req),
        .phy_we      (phy_we),
        .phy_addr    (phy_addr),
        .phy_wdata   (phy_wdata),
        .phy_done    (phy_done),
        .phy_rdata   (phy_rdata),
        .phy_err     (phy_err),
        .recover_evt (recover_evt),
        .err_flag    (err_flag),
        .busy        (busy)
    );
endmodule

// File: rtl/lsr_stall_recover_chk.sv
module lsr_stall_recover_chk #(
    parameter int DBG_W       = 32,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BUSY_BIT    = 4,
    parameter int STATE_W     = 6,
    parameter int STUCK_CODE  = 13,
    parameter int OVRD_ADDR   = 'h1005,
    parameter int DATA_EN_BIT = 5,
    parameter int PLL_EN_BIT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_en,
    input logic [DBG_W-1:0]  dbg_lo,
    input logic [DBG_W-1:0]  dbg_hi,
    input logic              phy_req,
    input logic              phy_we,
    input logic [ADDR_W-1:0] phy_addr,
    input logic [DATA_W-1:0] phy_wdata,
    input logic              phy_done,
    input logic              phy_err,
    input logic              recover_evt,
    input logic              err_flag,
    input logic              busy
);
    p_busy_bit_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && chk_en && dbg_hi[BUSY_BIT]) |=> !phy_req);

    p_state_mismatch_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && chk_en && (dbg_lo[STATE_W-1:0] != STATE_W'(STUCK_CODE))) |=> !phy_req);

    p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        recover_evt |=> !recover_evt);

    p_evt_with_set_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        recover_evt |-> (phy_req && !phy_we && (phy_addr == ADDR_W'(OVRD_ADDR))));

    p_write_bits_paired_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we) |-> (phy_wdata[DATA_EN_BIT] == phy_wdata[PLL_EN_BIT]));

    p_err_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_done && phy_err) |=> (!busy && !phy_req && err_flag));

    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_done) |=>
            (phy_req && $stable(phy_we) && $stable(phy_addr) && $stable(phy_wdata)));
endmodule

bind lsr_stall_recover lsr_stall_recover_chk #(
    .DBG_W      (DBG_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BUSY_BIT   (BUSY_BIT),
    .STATE_W    (STATE_W),
    .STUCK_CODE (STUCK_CODE),
    .OVRD_ADDR  (OVRD_ADDR),
    .DATA_EN_BIT(DATA_EN_BIT),
    .PLL_EN_BIT (PLL_EN_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (chk_en),
    .dbg_lo     (dbg_lo),
    .dbg_hi     (dbg_hi),
    .phy_req    (phy_req),
    .phy_we     (phy_we),
    .phy_addr   (phy_addr),
    .phy_wdata  (phy_wdata),
    .phy_done   (phy_done),
    .phy_err    (phy_err),
    .recover_evt(recover_evt),
    .err_flag   (err_flag),
    .busy       (busy)
);

// File: tb/lsr_stall_recover_tb.sv
module lsr_stall_recover_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic [31:0] dbg_lo = '0;
    logic [31:0] dbg_hi = '0;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_done = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        phy_err = 1'b0;
    logic        recover_evt, err_flag, busy;

    // PHY model state (written only by the model process)
    logic [15:0] ovrd_reg = '0;
    int          acc_idx = 0;
    int          lat_cnt = 0;
    // bench controls for the model
    logic        mdl_load = 1'b0;
    logic [15:0] mdl_load_val = '0;
    logic [15:0] rx_stat = '0;
    int          lat = 0;
    int          err_at = -1;

    int checks = 0;
    int errors = 0;
    int evt_cnt = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsr_stall_recover #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_done(phy_done), .phy_rdata(phy_rdata), .phy_err(phy_err),
        .recover_evt(recover_evt), .err_flag(err_flag), .busy(busy)
    );

    // PHY register port model
    always @(posedge clk) begin
        if (mdl_load) begin
            ovrd_reg <= mdl_load_val;
            acc_idx  <= 0;
            lat_cnt  <= 0;
            phy_done <= 1'b0;
            phy_err  <= 1'b0;
        end else if (phy_done) begin
            phy_done <= 1'b0;
            phy_err  <= 1'b0;
            lat_cnt  <= 0;
        end else if (phy_req) begin
            if (lat_cnt >= lat) begin
                phy_done  <= 1'b1;
                phy_err   <= (acc_idx == err_at);
                phy_rdata <= (phy_addr == 16'h100D) ? rx_stat :
                             (phy_addr == 16'h1005) ? ovrd_reg : 16'h0000;
                if (phy_we && phy_addr == 16'h1005 && acc_idx != err_at)
                    ovrd_reg <= phy_wdata;
                acc_idx <= acc_idx + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && recover_evt) evt_cnt <= evt_cnt + 1;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_accesses(input bit bsy, input bit st_ok, input bit rxv);
        if (bsy || !st_ok) return 0;
        if (rxv) return 1;
        return 5;
    endfunction

    function automatic logic [15:0] exp_final(input int acc, input logic [15:0] orig);
        return (acc == 5) ? (orig & ~16'h0028) : orig;
    endfunction

    task automatic prime(input logic [15:0] val, input logic [15:0] rxs, input int l, input int ea);
        @(negedge clk);
        mdl_load_val = val; rx_stat = rxs; lat = l; err_at = ea; mdl_load = 1'b1;
        @(negedge clk);
        mdl_load = 1'b0;
        evt_cnt = 0;
    endtask

    task automatic pulse_check(input logic [31:0] hi, input logic [31:0] lo);
        dbg_hi = hi; dbg_lo = lo; chk_en = 1'b1;
        @(negedge clk);
        chk_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] orig;
        int hc;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 req", phy_req, 0);
        chk("R1 evt", recover_evt, 0);
        chk("R1 err_flag", err_flag, 0);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;

        // R2 busy bit set with stuck state
        prime(16'h1234, 16'h0000, 1, -1);
        pulse_check(32'h0000_0010, 32'h0000_000D);
        chk("R2 busy after ignored check", busy, 0);
        wait_idle();
        chk("R2 accesses", acc_idx, 0);

        // R3 state not 0x0D
        prime(16'h1234, 16'h0000, 1, -1);
        pulse_check(32'h0, 32'hFFFF_FFCE);
        wait_idle();
        chk("R3 accesses", acc_idx, 0);
        chk("R3 no event", evt_cnt, 0);

        // R4 receive valid set
        prime(16'h00FF, 16'h0001, 2, -1);
        pulse_check(32'hFFFF_FFEF, 32'hAAAA_AA0D);
        chk("R4 busy next cycle", busy, 1);
        wait_idle();
        chk("R4 accesses", acc_idx, 1);
        chk("R4 no event", evt_cnt, 0);
        chk("R4 reg untouched", ovrd_reg, 16'h00FF);

        // R5 R6 R7 R8 full recovery with hold measurement
        orig = 16'hA5D2;
        prime(orig, 16'hFFFE, 1, -1);
        pulse_check(32'h0, 32'h0000_000D);
        begin
            int n = 0;
            while (!(phy_req && phy_we && phy_done && phy_wdata[5]) && n < 200) begin
                @(negedge clk); n++;
            end
        end
        chk("R5 event before hold", evt_cnt, 1);
        chk("R5 set written", ovrd_reg, orig | 16'h0028);
        @(negedge clk);
        hc = 0;
        while (!phy_req && hc < 1000) begin
            hc++;
            if (hc == 3) begin dbg_hi = 0; dbg_lo = 32'h0D; chk_en = 1'b1; end
            if (hc == 4) chk_en = 1'b0;
            @(negedge clk);
        end
        chk("R6 hold cycles", hc, HOLD);
        chk("R7 clear read addr", phy_addr, 16'h1005);
        wait_idle();
        chk("R7 accesses", acc_idx, 5);
        chk("R7 cleared", ovrd_reg, orig & ~16'h0028);
        chk("R8 single event", evt_cnt, 1);
        chk("R7 idle after", busy, 0);

        // R9 error on set read
        prime(16'h0F00, 16'h0000, 0, 1);
        pulse_check(32'h0, 32'h0D);
        wait_idle();
        chk("R9 err_flag", err_flag, 1);
        chk("R9 accesses", acc_idx, 2);
        chk("R9 reg untouched", ovrd_reg, 16'h0F00);
        // R9 error on clear read leaves overrides set
        prime(16'h0F00, 16'h0000, 0, 3);
        pulse_check(32'h0, 32'h0D);
        wait_idle();
        chk("R9 accesses abort late", acc_idx, 4);
        chk("R9 overrides stay", ovrd_reg, 16'h0F28);
        pulse_check(32'h10, 32'h0D);
        chk("R9 flag cleared", err_flag, 0);

        // random mix (R2 R3 R4 R5 R7 R10)
        begin
            int seed = 17;
            void'($urandom(seed));
        end
        for (int i = 0; i < 40; i++) begin
            bit bsy, st_ok, rxv;
            logic [31:0] hi, lo;
            logic [15:0] v;
            int ea;
            bsy   = ($urandom_range(0, 3) == 0);
            st_ok = ($urandom_range(0, 2) != 0);
            rxv   = ($urandom_range(0, 2) == 0);
            v     = 16'($urandom);
            hi    = $urandom;
            hi[4] = bsy;
            lo    = $urandom;
            lo[5:0] = st_ok ? 6'h0D : (6'($urandom_range(0, 62)) + 6'h0E);
            ea = exp_accesses(bsy, st_ok, rxv);
            prime(v, {15'($urandom), rxv}, $urandom_range(0, 3), -1);
            pulse_check(hi, lo);
            wait_idle();
            chk("R2/R3/R4 random accesses", acc_idx, ea);
            chk("R5 random event", evt_cnt, (ea == 5) ? 1 : 0);
            chk("R7 random final", ovrd_reg, exp_final(ea, v));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule